// File: doc/BRIEF.md
# Disk Drive Status Word Generator

This block holds a small set of latched condition bits for each drive on a disk controller and assembles a 16-bit status word whenever a status check is requested for one drive. Other controller logic reports conditions as single-cycle strobes tagged with a drive index. These conditions are seek in progress and seek finished, address miscompare, end of cylinder, and a write attempt. The block also watches the data-channel set-control strobe so that it can detect overruns.

On a read request the block selects the addressed drive and builds the word. It adds the summary error bit and the drive identity bit. If the drive's heads are unloaded, it replaces the contents with a bare not-ready report. The word is registered and appears one cycle after the request, with a valid strobe. In the same edge the block clears the drive's latched error bits. The seek-busy bit is left in place, because it follows the positioner rather than an error.

Top module: `disk_status_gen`

## Requirements
- R1: The word is presented on `stat_word` with `stat_valid` high exactly one cycle after `rd_req`, with these bit positions: 7 drive identity, 6 not ready, 5 end of cylinder, 4 address error, 3 flagged (write-protect fault), 2 seek busy, 1 data error (overrun), 0 any error; bits 15..8 are zero.
- R2: Bit 0 of a returned word is 1 exactly when at least one of bits 6, 5, 4, 3 or 1 of that word is 1; seek busy alone does not set it.
- R3: When `heads_loaded` for the selected drive is 0, the word carries only bit 6, the summary bit 0 and the identity bit 7, whatever that drive has latched.
- R4: Bit 7 equals bit 0 of `rd_drive` (set for drive 1), independent of any stored state.
- R5: A read clears the selected drive's latched end-of-cylinder, address-error, flagged and data-error bits, whether its heads are loaded or not; its seek-busy bit is kept.
- R6: `ev_write_try` on a drive whose `wprot` bit is 1 latches the flagged bit and pulses `write_abort` high for one cycle, one cycle later; on an unprotected drive it changes nothing and `write_abort` stays 0.
- R7: `dch_stc` while `ctl_busy` is 1 and `ctl_xfer` is 0 latches the data-error bit on drive `ctl_drive`; with `ctl_xfer` at 1 (or `ctl_busy` at 0) it has no effect.
- R8: Active-low synchronous reset clears every drive's latched bits, `stat_valid` and `write_abort`.
- R9: A condition strobe in the same cycle as a clearing read keeps its bit latched; the word returned by that read reflects only the state held before that edge.
- R10: `ev_seek_start` sets seek busy and `ev_seek_done` clears it; when both strike the same drive in the same cycle, busy ends up set.
- R11: `ev_addr_err` and `ev_end_cyl` latch their bits only on drive `ev_drive`; all other drives are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| heads_loaded | input | NUM_DRIVES | Per-drive heads-loaded level |
| wprot | input | NUM_DRIVES | Per-drive write-protect level |
| ev_drive | input | DRV_W | Drive addressed by the condition strobes |
| ev_seek_start | input | 1 | Seek started on `ev_drive` |
| ev_seek_done | input | 1 | Seek finished on `ev_drive` |
| ev_addr_err | input | 1 | Address miscompare on `ev_drive` |
| ev_end_cyl | input | 1 | End of cylinder reached on `ev_drive` |
| ev_write_try | input | 1 | Write transfer attempted on `ev_drive` |
| ctl_busy | input | 1 | Controller has a transfer command active |
| ctl_xfer | input | 1 | Data transfer phase is running |
| ctl_drive | input | DRV_W | Drive owning the active command |
| dch_stc | input | 1 | Data-channel set-control strobe |
| rd_req | input | 1 | Status check request |
| rd_drive | input | DRV_W | Drive whose status is requested |
| stat_word | output | 16 | Assembled status word |
| stat_valid | output | 1 | `stat_word` is valid this cycle |
| write_abort | output | 1 | Write ended by a protect fault |

## Verification
For each drive, the sweep latches every one of the 32 combinations of the five stored conditions, with the heads loaded and with them unloaded. The loaded cases show the bit layout and the summary logic. The unloaded cases show that stored state is masked and still cleared. The other drive is read after each pattern to show isolation. A second read shows the clear and that busy is kept. The inactive form of the write and set-control strobes is applied whenever the matching bit is meant to stay zero. Two directed same-cycle cases separate event priority from read clearing and seek start from seek done.

// File: rtl/dsw_pkg.sv
// Package: bit positions of the status word and per-drive latched state.
// Assumes a 16-bit word with the upper byte always zero.
package dsw_pkg;
    localparam int WORD_W  = 16;
    localparam int B_ID    = 7;
    localparam int B_NRDY  = 6;
    localparam int B_EOC   = 5;
    localparam int B_AER   = 4;
    localparam int B_FLG   = 3;
    localparam int B_BSY   = 2;
    localparam int B_DTE   = 1;
    localparam int B_ERR   = 0;

    typedef struct packed {
        logic eoc;
        logic aer;
        logic flg;
        logic bsy;
        logic dte;
    } drv_flags_t;
endpackage

// File: rtl/dsw_event_route.sv
// Module: dsw_event_route
// Turns drive-tagged condition strobes into per-drive set/clear lines,
// detects overruns and write-protect faults, and registers the abort pulse.
// Assumes strobes are one cycle wide and indices are in range.
module dsw_event_route #(
    parameter int NUM_DRIVES = 2,
    parameter int DRV_W      = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_DRIVES-1:0] wprot,
    input  logic [DRV_W-1:0]      ev_drive,
    input  logic                  ev_seek_start,
    input  logic                  ev_seek_done,
    input  logic                  ev_addr_err,
    input  logic                  ev_end_cyl,
    input  logic                  ev_write_try,
    input  logic                  ctl_busy,
    input  logic                  ctl_xfer,
    input  logic [DRV_W-1:0]      ctl_drive,
    input  logic                  dch_stc,
    output logic [NUM_DRIVES-1:0] set_go,
    output logic [NUM_DRIVES-1:0] set_end,
    output logic [NUM_DRIVES-1:0] set_aer,
    output logic [NUM_DRIVES-1:0] set_eoc,
    output logic [NUM_DRIVES-1:0] set_flg,
    output logic [NUM_DRIVES-1:0] set_dte,
    output logic                  write_abort
);
    logic overrun;
    logic prot_hit;

    // Overrun: set-control arrives while busy but outside the transfer phase.
    assign overrun  = dch_stc && ctl_busy && !ctl_xfer;
    // Write attempt meets a protected drive.
    assign prot_hit = ev_write_try && wprot[ev_drive];

    for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drv
        logic ev_hit;
        logic ctl_hit;
        // Decode which drive each strobe family addresses.
        assign ev_hit     = (ev_drive == DRV_W'(i));
        assign ctl_hit    = (ctl_drive == DRV_W'(i));
        assign set_go[i]  = ev_seek_start && ev_hit;
        assign set_end[i] = ev_seek_done && ev_hit;
        assign set_aer[i] = ev_addr_err && ev_hit;
        assign set_eoc[i] = ev_end_cyl && ev_hit;
        assign set_flg[i] = ev_write_try && ev_hit && wprot[i];
        assign set_dte[i] = overrun && ctl_hit;
    end

    // Register the transfer-abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) write_abort <= 1'b0;
        else        write_abort <= prot_hit;
    end

    p_abort_on_prot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_write_try && wprot[ev_drive]) |=> write_abort);
    p_no_abort_unprot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_write_try && wprot[ev_drive]) |=> !write_abort);
endmodule

// File: rtl/dsw_drive_flags.sv
// Module: dsw_drive_flags
// Latched condition bits of one drive. Set strobes win over a read clear;
// seek start wins over seek done. Busy survives reads.
module dsw_drive_flags
    import dsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_go,
    input  logic       set_end,
    input  logic       set_aer,
    input  logic       set_eoc,
    input  logic       set_flg,
    input  logic       set_dte,
    input  logic       rd_clr,
    output drv_flags_t flags
);
    drv_flags_t nxt;

    // Next state: clear on read first, then apply events so they take priority.
    always_comb begin
        nxt = flags;
        if (rd_clr) begin
            nxt.eoc = 1'b0;
            nxt.aer = 1'b0;
            nxt.flg = 1'b0;
            nxt.dte = 1'b0;
        end
        if (set_end) nxt.bsy = 1'b0;
        if (set_go)  nxt.bsy = 1'b1;
        if (set_aer) nxt.aer = 1'b1;
        if (set_eoc) nxt.eoc = 1'b1;
        if (set_flg) nxt.flg = 1'b1;
        if (set_dte) nxt.dte = 1'b1;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= nxt;
    end

    p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !set_aer && !set_eoc && !set_flg && !set_dte)
        |=> (!flags.aer && !flags.eoc && !flags.flg && !flags.dte));
    p_busy_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !set_go && !set_end) |=> $stable(flags.bsy));
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && set_aer) |=> flags.aer);
    p_start_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_go |=> flags.bsy);
endmodule

// File: rtl/dsw_word_build.sv
// Module: dsw_word_build
// Selects a drive, composes its status word (summary, identity, not-ready
// masking), registers it with a valid strobe and issues the read clear.
module dsw_word_build
    import dsw_pkg::*;
#(
    parameter int NUM_DRIVES = 2,
    parameter int DRV_W      = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  drv_flags_t [NUM_DRIVES-1:0]      flags_all,
    input  logic [NUM_DRIVES-1:0]            heads_loaded,
    input  logic                             rd_req,
    input  logic [DRV_W-1:0]                 rd_drive,
    output logic [NUM_DRIVES-1:0]            rd_clr,
    output logic [WORD_W-1:0]                stat_word,
    output logic                             stat_valid
);
    drv_flags_t         sel;
    logic [WORD_W-1:0]  word_c;

    assign sel = flags_all[rd_drive];

    // Compose the word from the selected drive's stored state.
    always_comb begin
        word_c = '0;
        if (heads_loaded[rd_drive]) begin
            word_c[B_EOC] = sel.eoc;
            word_c[B_AER] = sel.aer;
            word_c[B_FLG] = sel.flg;
            word_c[B_BSY] = sel.bsy;
            word_c[B_DTE] = sel.dte;
        end else begin
            word_c[B_NRDY] = 1'b1;
        end
        word_c[B_ERR] = word_c[B_NRDY] | word_c[B_EOC] | word_c[B_AER]
                      | word_c[B_FLG] | word_c[B_DTE];
        word_c[B_ID]  = rd_drive[0];
    end

    for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_clr
        // Clear strobe for the drive being read.
        assign rd_clr[i] = rd_req && (rd_drive == DRV_W'(i));
    end

    // Output register for word and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_word  <= '0;
            stat_valid <= 1'b0;
        end else begin
            stat_valid <= rd_req;
            if (rd_req) stat_word <= word_c;
        end
    end

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> stat_valid);
    p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !stat_valid);
    p_unloaded_only_nrdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !heads_loaded[rd_drive])
        |=> (stat_word[B_NRDY] && stat_word[B_ERR] && stat_word[5:1] == 5'b0));
    p_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (stat_word[B_ID] == $past(rd_drive[0])));
endmodule

// File: rtl/disk_status_gen.sv
// Module: disk_status_gen (top)
// Per-drive status latching and status-word generation for a disk
// controller. Assumes condition strobes are single-cycle pulses.
module disk_status_gen
    import dsw_pkg::*;
#(
    parameter int NUM_DRIVES = 2,
    parameter int DRV_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_DRIVES-1:0] heads_loaded,
    input  logic [NUM_DRIVES-1:0] wprot,
    input  logic [DRV_W-1:0]      ev_drive,
    input  logic                  ev_seek_start,
    input  logic                  ev_seek_done,
    input  logic                  ev_addr_err,
    input  logic                  ev_end_cyl,
    input  logic                  ev_write_try,
    input  logic                  ctl_busy,
    input  logic                  ctl_xfer,
    input  logic [DRV_W-1:0]      ctl_drive,
    input  logic                  dch_stc,
    input  logic                  rd_req,
    input  logic [DRV_W-1:0]      rd_drive,
    output logic [WORD_W-1:0]     stat_word,
    output logic                  stat_valid,
    output logic                  write_abort
);
    logic [NUM_DRIVES-1:0]       set_go, set_end, set_aer, set_eoc, set_flg, set_dte;
    logic [NUM_DRIVES-1:0]       rd_clr;
    drv_flags_t [NUM_DRIVES-1:0] flags_all;

    dsw_event_route #(.NUM_DRIVES(NUM_DRIVES), .DRV_W(DRV_W)) u_route (
        .clk(clk), .rst_n(rst_n), .wprot(wprot), .ev_drive(ev_drive),
        .ev_seek_start(ev_seek_start), .ev_seek_done(ev_seek_done),
        .ev_addr_err(ev_addr_err), .ev_end_cyl(ev_end_cyl),
        .ev_write_try(ev_write_try), .ctl_busy(ctl_busy), .ctl_xfer(ctl_xfer),
        .ctl_drive(ctl_drive), .dch_stc(dch_stc),
        .set_go(set_go), .set_end(set_end), .set_aer(set_aer),
        .set_eoc(set_eoc), .set_flg(set_flg), .set_dte(set_dte),
        .write_abort(write_abort)
    );

    for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_flags
        dsw_drive_flags u_flags (
            .clk(clk), .rst_n(rst_n),
            .set_go(set_go[i]), .set_end(set_end[i]), .set_aer(set_aer[i]),
            .set_eoc(set_eoc[i]), .set_flg(set_flg[i]), .set_dte(set_dte[i]),
            .rd_clr(rd_clr[i]), .flags(flags_all[i])
        );
    end

    dsw_word_build #(.NUM_DRIVES(NUM_DRIVES), .DRV_W(DRV_W)) u_build (
        .clk(clk), .rst_n(rst_n), .flags_all(flags_all),
        .heads_loaded(heads_loaded), .rd_req(rd_req), .rd_drive(rd_drive),
        .rd_clr(rd_clr), .stat_word(stat_word), .stat_valid(stat_valid)
    );

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (stat_word[15:8] == 8'h00));
endmodule

// File: tb/disk_status_gen_tb.sv
`timescale 1ns/1ps
module disk_status_gen_tb;
    localparam int ND = 2;
    localparam int DW = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND-1:0] heads_loaded = '1;
    logic [ND-1:0] wprot = '0;
    logic [DW-1:0] ev_drive = '0;
    logic          ev_seek_start = 0, ev_seek_done = 0, ev_addr_err = 0;
    logic          ev_end_cyl = 0, ev_write_try = 0;
    logic          ctl_busy = 0, ctl_xfer = 0, dch_stc = 0;
    logic [DW-1:0] ctl_drive = '0;
    logic          rd_req = 0;
    logic [DW-1:0] rd_drive = '0;
    logic [15:0]   stat_word;
    logic          stat_valid;
    logic          write_abort;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    disk_status_gen #(.NUM_DRIVES(ND)) u_dut (
        .clk(clk), .rst_n(rst_n), .heads_loaded(heads_loaded), .wprot(wprot),
        .ev_drive(ev_drive), .ev_seek_start(ev_seek_start),
        .ev_seek_done(ev_seek_done), .ev_addr_err(ev_addr_err),
        .ev_end_cyl(ev_end_cyl), .ev_write_try(ev_write_try),
        .ctl_busy(ctl_busy), .ctl_xfer(ctl_xfer), .ctl_drive(ctl_drive),
        .dch_stc(dch_stc), .rd_req(rd_req), .rd_drive(rd_drive),
        .stat_word(stat_word), .stat_valid(stat_valid), .write_abort(write_abort)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
        end
    endtask

    // Expected word: m bit0 eoc, 1 aer, 2 flg, 3 bsy, 4 dte.
    function automatic logic [15:0] exp_word(input int d, input logic loaded, input logic [4:0] m);
        logic [15:0] w = '0;
        if (loaded) begin
            w[5] = m[0]; w[4] = m[1]; w[3] = m[2]; w[2] = m[3]; w[1] = m[4];
        end else begin
            w[6] = 1'b1;
        end
        w[0] = w[6] | w[5] | w[4] | w[3] | w[1];
        w[7] = d[0];
        return w;
    endfunction

    task automatic do_read(input int d, output logic [15:0] w);
        rd_req = 1'b1; rd_drive = DW'(d);
        @(negedge clk);
        rd_req = 1'b0;
        check("R1 valid", {15'b0, stat_valid}, 16'h0001);
        w = stat_word;
    endtask

    initial begin
        logic [15:0] w;
        repeat (3) @(negedge clk);
        check("R8 reset valid", {15'b0, stat_valid}, 16'h0000);
        check("R8 reset abort", {15'b0, write_abort}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < ND; d++) begin
            do_read(d, w);
            check("R8 reset state", w, exp_word(d, 1'b1, 5'b0));
        end

        // Sweep: drive x stored pattern x heads state.
        for (int d = 0; d < ND; d++) begin
            for (int m = 0; m < 32; m++) begin
                for (int l = 0; l < 2; l++) begin
                    logic [4:0] mm = 5'(m);
                    heads_loaded = '1;
                    heads_loaded[d] = l[0];
                    ev_drive = DW'(d);
                    if (mm[0]) begin ev_end_cyl = 1; @(negedge clk); ev_end_cyl = 0; end
                    if (mm[1]) begin ev_addr_err = 1; @(negedge clk); ev_addr_err = 0; end
                    if (mm[3]) begin ev_seek_start = 1; @(negedge clk); ev_seek_start = 0; end
                    // Write attempt, protected or not (R6).
                    wprot[d] = mm[2];
                    ev_write_try = 1; @(negedge clk); ev_write_try = 0;
                    check("R6 abort", {15'b0, write_abort}, {15'b0, mm[2]});
                    wprot[d] = 0;
                    // Set-control: overrun only outside transfer phase (R7).
                    ctl_busy = 1; ctl_xfer = !mm[4]; ctl_drive = DW'(d); dch_stc = 1;
                    @(negedge clk);
                    dch_stc = 0; ctl_busy = 0; ctl_xfer = 0;
                    do_read(d, w);
                    check(l ? "R2 loaded word" : "R3 unloaded word", w, exp_word(d, l[0], mm));
                    do_read(1 - d, w);
                    check("R11 other drive", w, exp_word(1 - d, 1'b1, 5'b0));
                    do_read(d, w);
                    check("R5 after clear", w, exp_word(d, l[0], {1'b0, mm[3], 3'b0}));
                    ev_seek_done = 1; @(negedge clk); ev_seek_done = 0;
                    heads_loaded = '1;
                    do_read(d, w);
                    check("R10 busy cleared", w, exp_word(d, 1'b1, 5'b0));
                end
            end
        end

        // R9: event and clearing read in the same cycle.
        ev_drive = 0; ev_addr_err = 1; rd_req = 1; rd_drive = 0;
        @(negedge clk);
        ev_addr_err = 0; rd_req = 0;
        check("R9 word before event", stat_word, 16'h0000);
        do_read(0, w);
        check("R9 event kept", w, 16'h0011);

        // R10: seek start and done together leave busy set; busy alone gives no summary (R2).
        ev_drive = 1; ev_seek_start = 1; ev_seek_done = 1;
        @(negedge clk);
        ev_seek_start = 0; ev_seek_done = 0;
        do_read(1, w);
        check("R10 start wins", w, 16'h0084);
        check("R4 identity drive1", {15'b0, w[7]}, 16'h0001);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule